// File: doc/BRIEF.md
# Return-Address Stack Controller

This block keeps the return addresses of a small processor in its byte-wide data RAM. It does not use a separate register file. Eight entries sit in the RAM as byte pairs at addresses 8 to 23. A 3-bit pointer selects the entry, and the core copies that pointer into its status word. A subroutine call or an interrupt entry asks for a save. The block stores the 12-bit return address, together with the upper four bits of the status word, in the entry at the pointer, and then advances the pointer. A return asks for a restore. The block steps the pointer back first, then reads the pair and presents the address as the new program counter.

There are two kinds of return. The plain return reloads only the program counter. The status-restoring return also hands back the saved nibble and pulses a load strobe. The pointer wraps around silently in both directions. A ninth nested save therefore overwrites the oldest entry, and a return at pointer 0 reads entry 7. Each save or restore moves one RAM byte per cycle, and `busy` stays high while a sequence runs.

Top module: `rstack_ctrl`

## Requirements
- R1: After reset, `pc_out` is 0, `sp_out` is 0, and `busy`, `psw_load` and `ram_we` are all 0.
- R2: Entry n lives at RAM addresses 8+2n (even) and 9+2n (odd). The even byte holds PC[7:0]. The odd byte holds the status nibble in bits [7:4] and PC[11:8] in bits [3:0].
- R3: A call accepted at a clock edge is followed by two write cycles. The first writes the even byte and the second writes the odd byte of the entry at the current pointer, with `busy` high in both cycles. `sp_out` rises by one at the end of the second cycle.
- R4: A save made at pointer 7 writes addresses 22 and 23 and leaves the pointer at 0. The next save then overwrites addresses 8 and 9.
- R5: A return accepted at a clock edge decrements `sp_out` at that same edge. The block then reads the even byte and the odd byte of the entry now selected, and follows with one finishing cycle, so `busy` is high for three cycles. `pc_out` carries the restored address from the end of the third cycle.
- R6: A return accepted at pointer 0 moves the pointer to 7 and restores the entry at addresses 22 and 23.
- R7: A plain return (`ret_psw` = 0) leaves `psw_hi_out` unchanged and does not pulse `psw_load`.
- R8: A status-restoring return (`ret_psw` = 1) sets `psw_hi_out` to bits [7:4] of the odd byte, at the same edge that updates `pc_out`. `psw_load` is high for exactly one cycle after that edge.
- R9: `call_req` and `ret_req` are ignored while `busy` is high. They cause no extra RAM write and no pointer change.
- R10: When `call_req` and `ret_req` are both high in an idle cycle, the call is taken and the return is dropped.
- R11: `pc_out` changes only at the end of a return sequence. A save leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| call_req | input | 1 | Save request (call or interrupt), sampled when idle |
| ret_req | input | 1 | Restore request, sampled when idle |
| ret_psw | input | 1 | With `ret_req`: 1 also restores the status nibble |
| pc_in | input | 12 | Return address to save |
| psw_hi_in | input | 4 | Current upper status nibble to save |
| pc_out | output | 12 | Program counter restored by the last return |
| psw_hi_out | output | 4 | Status nibble restored by the last status-restoring return |
| psw_load | output | 1 | One-cycle strobe: `psw_hi_out` has just been restored |
| sp_out | output | 3 | Stack pointer field for the status word |
| busy | output | 1 | A save or restore sequence is running |
| ram_addr | output | 8 | Data RAM byte address |
| ram_we | output | 1 | Data RAM write enable |
| ram_re | output | 1 | Data RAM read enable |
| ram_wdata | output | 8 | Data RAM write byte |
| ram_rdata | input | 8 | Data RAM read byte, one cycle after the address |

## Verification
A save accepted at edge k drives the even-byte write in the cycle after k and the odd-byte write in the cycle after that. The pointer moves at edge k+2. The bench samples each of these at the falling edge inside the cycle, so the RAM model has already stored the bytes when they are compared. A restore moves the pointer at edge k itself and reads over the next two cycles. `pc_out`, `psw_hi_out` and `psw_load` change at edge k+3, and the bench checks them at the falling edge after k+3. It checks `psw_load` again one cycle later to confirm the strobe lasts one cycle. The sweep makes nine nested saves so that the pointer wraps upward, then eight mixed-kind restores, one of which wraps downward. Expected contents come from a bench-side array indexed by the bench's own pointer.

// File: rtl/rstack_pkg.sv
package rstack_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WR_LO,
        ST_WR_HI,
        ST_RD_LO,
        ST_RD_HI,
        ST_RD_FIN
    } rstack_st_e;

endpackage

// File: rtl/rstack_ptr.sv
module rstack_ptr #(
    parameter int SP_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            inc,
    input  logic            dec,
    output logic [SP_W-1:0] sp
);
    localparam logic [SP_W-1:0] ONE = SP_W'(1);

    logic [SP_W-1:0] sp_d, sp_q;

    always_comb begin
        sp_d = sp_q;
        if (inc) begin
            sp_d = sp_q + ONE;
        end else if (dec) begin
            sp_d = sp_q - ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign sp = sp_q;

    AST_SP_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> sp_q == $past(sp_q) + ONE); // R4

    AST_SP_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |=> sp_q == $past(sp_q) - ONE); // R6

endmodule

// File: rtl/rstack_addr.sv
module rstack_addr #(
    parameter int SP_W = 3,
    parameter int AW   = 8,
    parameter int BASE = 8
) (
    input  logic [SP_W-1:0] sp,
    input  logic            hi_sel,
    output logic [AW-1:0]   addr
);
    localparam logic [AW-1:0] BASE_V = AW'(BASE);

    always_comb begin
        addr = BASE_V + AW'({sp, hi_sel});
    end

endmodule

// File: rtl/rstack_ctrl.sv
module rstack_ctrl
    import rstack_pkg::*;
#(
    parameter int PC_W  = 12,
    parameter int NIB_W = 4,
    parameter int SP_W  = 3,
    parameter int AW    = 8,
    parameter int BASE  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             call_req,
    input  logic             ret_req,
    input  logic             ret_psw,
    input  logic [PC_W-1:0]  pc_in,
    input  logic [NIB_W-1:0] psw_hi_in,
    output logic [PC_W-1:0]  pc_out,
    output logic [NIB_W-1:0] psw_hi_out,
    output logic             psw_load,
    output logic [SP_W-1:0]  sp_out,
    output logic             busy,
    output logic [AW-1:0]    ram_addr,
    output logic             ram_we,
    output logic             ram_re,
    output logic [7:0]       ram_wdata,
    input  logic [7:0]       ram_rdata
);
    localparam int              PC_HI_W = PC_W - 8;
    localparam int              DEPTH   = 1 << SP_W;
    localparam logic [AW-1:0]   ADDR_LO = AW'(BASE);
    localparam logic [AW-1:0]   ADDR_HI = AW'(BASE + 2 * DEPTH - 1);

    typedef struct packed {
        rstack_st_e       st;
        logic [PC_W-1:0]  pc;
        logic [PC_W-1:0]  save_pc;
        logic [NIB_W-1:0] save_nib;
        logic [7:0]       lo;
        logic [NIB_W-1:0] nib;
        logic             nib_ld;
        logic             want_psw;
    } regs_t;

    regs_t r_d, r_q;

    logic            sp_inc, sp_dec, hi_sel;
    logic [SP_W-1:0] sp;

    rstack_ptr #(.SP_W(SP_W)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (sp_inc),
        .dec   (sp_dec),
        .sp    (sp)
    );

    rstack_addr #(.SP_W(SP_W), .AW(AW), .BASE(BASE)) u_addr (
        .sp     (sp),
        .hi_sel (hi_sel),
        .addr   (ram_addr)
    );

    always_comb begin
        r_d        = r_q;
        r_d.nib_ld = 1'b0;
        sp_inc     = 1'b0;
        sp_dec     = 1'b0;
        hi_sel     = 1'b0;
        ram_we     = 1'b0;
        ram_re     = 1'b0;
        ram_wdata  = '0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (call_req) begin
                    r_d.save_pc  = pc_in;
                    r_d.save_nib = psw_hi_in;
                    r_d.st       = ST_WR_LO;
                end else if (ret_req) begin
                    sp_dec       = 1'b1;
                    r_d.want_psw = ret_psw;
                    r_d.st       = ST_RD_LO;
                end
            end
            ST_WR_LO: begin
                ram_we    = 1'b1;
                ram_wdata = r_q.save_pc[7:0];
                r_d.st    = ST_WR_HI;
            end
            ST_WR_HI: begin
                ram_we    = 1'b1;
                hi_sel    = 1'b1;
                ram_wdata = {r_q.save_nib, r_q.save_pc[PC_W-1:8]};
                sp_inc    = 1'b1;
                r_d.st    = ST_IDLE;
            end
            ST_RD_LO: begin
                ram_re = 1'b1;
                r_d.st = ST_RD_HI;
            end
            ST_RD_HI: begin
                ram_re = 1'b1;
                hi_sel = 1'b1;
                r_d.lo = ram_rdata;
                r_d.st = ST_RD_FIN;
            end
            ST_RD_FIN: begin
                r_d.pc = {ram_rdata[PC_HI_W-1:0], r_q.lo};
                if (r_q.want_psw) begin
                    r_d.nib    = ram_rdata[7 -: NIB_W];
                    r_d.nib_ld = 1'b1;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign pc_out     = r_q.pc;
    assign psw_hi_out = r_q.nib;
    assign psw_load   = r_q.nib_ld;
    assign sp_out     = sp;
    assign busy       = (r_q.st != ST_IDLE);

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we || ram_re) |-> (ram_addr >= ADDR_LO && ram_addr <= ADDR_HI)); // R2

    AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !ram_addr[0]) |=> (ram_we && ram_addr[0])); // R3

    AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(pc_out)); // R11

    AST_IDLE_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(ram_we || ram_re)); // R9

    AST_LOAD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        psw_load |=> !psw_load); // R8

endmodule

// File: tb/rstack_ctrl_bench.sv
module rstack_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_req = 1'b0, ret_req = 1'b0, ret_psw = 1'b0;
    logic [11:0] pc_in = '0;
    logic [3:0]  psw_hi_in = '0;
    logic [11:0] pc_out;
    logic [3:0]  psw_hi_out;
    logic        psw_load, busy, ram_we, ram_re;
    logic [2:0]  sp_out;
    logic [7:0]  ram_addr, ram_wdata;
    logic [7:0]  ram_rdata = '0;
    logic [7:0]  mem [0:255];

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    logic [11:0] m_pc  [0:7];
    logic [3:0]  m_nib [0:7];
    logic [3:0]  exp_psw = '0;
    int          m_sp = 0;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= ram_wdata;
        ram_rdata <= mem[ram_addr];
    end

    rstack_ctrl u_rstack_ctrl (
        .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
        .ret_psw(ret_psw), .pc_in(pc_in), .psw_hi_in(psw_hi_in),
        .pc_out(pc_out), .psw_hi_out(psw_hi_out), .psw_load(psw_load),
        .sp_out(sp_out), .busy(busy), .ram_addr(ram_addr), .ram_we(ram_we),
        .ram_re(ram_re), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_call(input logic [11:0] p, input logic [3:0] nb,
                           input bit with_ret, input bit poke);
        int s0 = int'(sp_out);
        int e  = 8 + 2 * s0;
        logic [11:0] pc_before = pc_out;
        @(negedge clk);
        call_req = 1'b1; ret_req = with_ret; pc_in = p; psw_hi_in = nb;
        cyc();
        call_req = poke; ret_req = poke; pc_in = ~p; psw_hi_in = ~nb;
        chk("R3 busy write lo", int'(busy), 1);
        chk("R3 we lo", int'(ram_we), 1);
        chk("R2 addr lo", int'(ram_addr), e);
        chk(with_ret ? "R10 no sp move on call" : "R3 sp held", int'(sp_out), s0);
        cyc();
        call_req = 1'b0; ret_req = 1'b0;
        chk("R3 busy write hi", int'(busy), 1);
        chk("R2 addr hi", int'(ram_addr), e + 1);
        cyc();
        chk("R3 busy done", int'(busy), 0);
        chk(s0 == 7 ? "R4 sp wrap" : "R3 sp inc", int'(sp_out), (s0 + 1) % 8);
        chk("R2 even byte", int'(mem[e]), int'(p[7:0]));
        chk("R2 odd byte", int'(mem[e + 1]), int'({nb, p[11:8]}));
        chk("R11 pc kept on call", int'(pc_out), int'(pc_before));
        m_pc[s0] = p; m_nib[s0] = nb; m_sp = (s0 + 1) % 8;
        if (poke) begin
            cyc(); cyc();
            chk("R9 no restart", int'(busy), 0);
            chk("R9 sp unchanged", int'(sp_out), m_sp);
        end
    endtask

    task automatic do_ret(input bit mode);
        int s0 = int'(sp_out);
        int se = (s0 + 7) % 8;
        @(negedge clk);
        ret_req = 1'b1; ret_psw = mode;
        cyc();
        ret_req = 1'b0; ret_psw = 1'b0;
        chk(s0 == 0 ? "R6 sp underflow" : "R5 sp dec first", int'(sp_out), se);
        chk("R5 busy rd lo", int'(busy), 1);
        chk("R5 read lo", int'(ram_re), 1);
        chk(s0 == 0 ? "R6 addr lo" : "R5 addr lo", int'(ram_addr), 8 + 2 * se);
        cyc();
        chk("R5 addr hi", int'(ram_addr), 9 + 2 * se);
        cyc();
        chk("R5 busy fin", int'(busy), 1);
        cyc();
        chk("R5 busy done", int'(busy), 0);
        chk(s0 == 0 ? "R6 pc restored" : "R5 pc restored", int'(pc_out), int'(m_pc[se]));
        if (mode) exp_psw = m_nib[se];
        chk(mode ? "R8 psw_load" : "R7 no psw_load", int'(psw_load), int'(mode));
        chk(mode ? "R8 nibble" : "R7 nibble kept", int'(psw_hi_out), int'(exp_psw));
        cyc();
        chk("R8 strobe one cycle", int'(psw_load), 0);
        m_sp = se;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 pc", int'(pc_out), 0);
        chk("R1 sp", int'(sp_out), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 psw_load", int'(psw_load), 0);
        rst_n = 1'b1;
        cyc();
        chk("R1 we", int'(ram_we), 0);

        for (int i = 0; i < 9; i++) begin
            do_call(12'((i * 'h1A7 + 'h0F3) & 'hFFF), 4'((i * 5 + 3) & 15), 1'b0, 1'b0);
        end
        chk("R4 overwrite 8", int'(mem[8]), int'(m_pc[0][7:0]));

        for (int i = 0; i < 8; i++) begin
            do_ret(i[0]);
        end

        do_call(12'hA5C, 4'h9, 1'b0, 1'b1);
        do_call(12'h3E1, 4'h6, 1'b1, 1'b0);
        do_ret(1'b1);
        do_ret(1'b0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule